// File: doc/BRIEF.md
# Clock Mode Control Register

This block is the byte-wide control register of a clock generator. It sits on a simple register bus with a write strobe, write data and combinational read data, and uses a synchronous active-high reset. It holds a frequency-range bit, a reference-source select bit, a two-bit clock-mode field and an oscillator stop-enable bit. It enforces the rules on when each field may change: two fields accept only their first write after reset. The mode field can be locked out of the external-reference encodings by the first write it sees.

A mode write that is accepted and differs from the stored value opens a pending change. The effective mode, which drives the clock multiplexing outside this block, keeps the old value until a completion pulse arrives. Bypassed-external mode also needs the external reference to report ready. The block also outputs the FLL loop prescale factor that follows from the effective mode and the range bit. The oscillator, the FLL and the clock switch are outside the block. Their status and completion signals arrive on ports.

Top module: `clkmode_ctl_reg`

## Requirements
- R1: After reset, rd_data reads 0x05 (range = 1, all else 0, stop-enable = 1), eff_mode is 00, chg_pending is 0 and prescale is 1.
- R2: The range field (bit 2) takes its value from the first register write after reset; later writes leave it unchanged until the next reset.
- R3: The reference select field (bit 1; 1 = crystal or resonator, 0 = external clock) takes its value from the first register write after reset and is then frozen until reset.
- R4: The stop-enable field (bit 0) is written by every register write; bits 7, 6 and 3 always read 0 and ignore writes.
- R5: The mode field (bits 5:4; 00 self-clocked, 01 FLL with internal reference, 10 FLL bypassed with external reference, 11 FLL with external reference) accepts writes at any time. If the first mode write after reset has bit 5 = 0, later writes with bit 5 = 1 leave the field unchanged until reset.
- R6: eff_mode becomes 10 only on a completion taken while ref_ready is 1; without ref_ready the change stays pending.
- R7: While chg_pending is 1, a write leaves the mode field unchanged, and it does not count as the first mode write.
- R8: An accepted mode write that differs from the stored mode sets chg_pending on the next cycle, and a write of the same value does not. eff_mode holds its value while the change is pending. A chg_done pulse that is allowed to complete the change copies the stored mode to eff_mode and clears chg_pending on the next cycle.
- R9: While gen_off is 1, a pending change does not complete and the stored mode field keeps its value.
- R10: prescale is 1 when eff_mode is 10 or 11 and range is 1, and 64 when eff_mode is 10 or 11 and range is 0. It is 1 in modes 00 and 01, whatever the range value.
- R11: When a write and a completing chg_done arrive in the same cycle while a change is pending, the completion is taken and the write leaves the mode field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Stored register contents |
| ref_ready | input | 1 | External reference ready status |
| chg_done | input | 1 | Mode change completion pulse |
| gen_off | input | 1 | Clock generator is in off mode |
| eff_mode | output | 2 | Currently effective clock mode |
| chg_pending | output | 1 | A mode change is in progress |
| prescale | output | 7 | FLL loop prescale factor (1 or 64) |

## Verification
A register write and a completion pulse can land in the same cycle while a change is pending. The completion must then win, and the write must not touch the mode field or count as the first mode write. The bench drives wr_en and chg_done high in one cycle during a pending change to a new mode. It expects eff_mode to take the old target and rd_data to keep it. A random phase then mixes writes, pulses, ref_ready and gen_off freely, and a behavioural model checks every cycle for such collisions.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int STOP_BIT  = 0;
  localparam int REF_BIT   = 1;
  localparam int RANGE_BIT = 2;
  localparam int MODE_LSB  = 4;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SELF    = 2'b00,
    MODE_FLL_INT = 2'b01,
    MODE_BYP_EXT = 2'b10,
    MODE_FLL_EXT = 2'b11
  } clk_mode_e;
endpackage

// File: rtl/clkmode_once_bit.sv
module clkmode_once_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= RST_VAL;
      seen_q <= 1'b0;
    end else if (wr_en && !seen_q) begin
      q      <= wr_bit;
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/clkmode_sel.sv
module clkmode_sel
  import clkmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              gen_off,
  input  logic              ref_ready,
  input  logic              chg_done,
  output logic [MODE_W-1:0] mode_q,
  output logic [MODE_W-1:0] eff_q,
  output logic              pend_q
);
  logic first_q;
  logic lock_q;
  logic take;
  logic finish;

  // accepted write: nothing pending and not blocked by lock-out
  assign take   = wr_en && !pend_q && !(lock_q && wr_mode[MODE_W-1]);
  assign finish = pend_q && chg_done && !gen_off &&
                  ((mode_q != MODE_BYP_EXT) || ref_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_SELF;
      eff_q   <= MODE_SELF;
      pend_q  <= 1'b0;
      first_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (wr_en && !pend_q && !first_q) begin
        first_q <= 1'b1;
        lock_q  <= !wr_mode[MODE_W-1];
      end
      if (finish) begin
        eff_q  <= mode_q;
        pend_q <= 1'b0;
      end
      if (take && (wr_mode != mode_q)) begin
        mode_q <= wr_mode;
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkmode_prescale.sv
module clkmode_prescale #(
  parameter int P_HI = 1,
  parameter int P_LO = 64,
  parameter int PW   = 7
) (
  input  logic [1:0]    eff_mode,
  input  logic          range_hi,
  output logic [PW-1:0] prescale
);
  // bit 1 of the mode marks the external-reference encodings
  always_comb begin
    if (eff_mode[1] && !range_hi) prescale = PW'(P_LO);
    else                          prescale = PW'(P_HI);
  end
endmodule

// File: rtl/clkmode_ctl_reg.sv
module clkmode_ctl_reg
  import clkmode_pkg::*;
#(
  parameter int DW   = 8,
  parameter int P_HI = 1,
  parameter int P_LO = 64,
  parameter int PW   = $clog2(P_LO + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ref_ready,
  input  logic          chg_done,
  input  logic          gen_off,
  output logic [1:0]    eff_mode,
  output logic          chg_pending,
  output logic [PW-1:0] prescale
);
  localparam int ONCE_N = 2;

  logic [ONCE_N-1:0] once_q;
  logic              stop_q;
  logic [MODE_W-1:0] mode_q;
  logic              unused_bits;

  assign unused_bits = ^{wr_data[DW-1:MODE_LSB+MODE_W], wr_data[MODE_LSB-1:RANGE_BIT+1]};

  // index 0: range (resets high), index 1: reference select (resets low)
  for (genvar g = 0; g < ONCE_N; g++) begin : g_once
    localparam int   POS = (g == 0) ? RANGE_BIT : REF_BIT;
    localparam logic RV  = (g == 0) ? 1'b1 : 1'b0;
    clkmode_once_bit #(.RST_VAL(RV)) u_once (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_data[POS]), .q(once_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        stop_q <= 1'b1;
    else if (wr_en) stop_q <= wr_data[STOP_BIT];
  end

  clkmode_sel u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_mode(wr_data[MODE_LSB +: MODE_W]),
    .gen_off(gen_off), .ref_ready(ref_ready), .chg_done(chg_done),
    .mode_q(mode_q), .eff_q(eff_mode), .pend_q(chg_pending)
  );

  clkmode_prescale #(.P_HI(P_HI), .P_LO(P_LO), .PW(PW)) u_pre (
    .eff_mode(eff_mode), .range_hi(once_q[0]), .prescale(prescale)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[STOP_BIT]            = stop_q;
    rd_data[REF_BIT]             = once_q[1];
    rd_data[RANGE_BIT]           = once_q[0];
    rd_data[MODE_LSB +: MODE_W]  = mode_q;
  end
endmodule

// File: rtl/clkmode_ctl_chk.sv
module clkmode_ctl_chk
  import clkmode_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          ref_ready,
  input logic          chg_done,
  input logic          gen_off,
  input logic [1:0]    eff_mode,
  input logic          chg_pending,
  input logic [PW-1:0] prescale
);
  logic seen_q, first_q, lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q  <= 1'b0;
      first_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      if (wr_en) seen_q <= 1'b1;
      if (wr_en && !chg_pending && !first_q) begin
        first_q <= 1'b1;
        lock_q  <= !wr_data[MODE_LSB+1];
      end
    end
  end

  // R2
  range_once_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |=> $stable(rd_data[RANGE_BIT]));
  // R3
  refsel_once_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |=> $stable(rd_data[REF_BIT]));
  // R5
  mode_lockout_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> !rd_data[MODE_LSB+1]);
  // R6
  bypass_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_mode != MODE_BYP_EXT) |=> ((eff_mode != MODE_BYP_EXT) || $past(ref_ready)));
  // R7
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_pending && wr_en) |=> $stable(rd_data[MODE_LSB +: MODE_W]));
  // R8
  eff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_pending && !chg_done) |=> $stable(eff_mode));
  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_pending && gen_off) |=> (chg_pending && $stable(eff_mode)));
  // R10
  prescale_int_chk: assert property (@(posedge clk) disable iff (rst)
    !eff_mode[1] |-> (prescale == PW'(1)));
  // R10
  prescale_pow_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(prescale) == 1);
endmodule

bind clkmode_ctl_reg clkmode_ctl_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .ref_ready(ref_ready), .chg_done(chg_done), .gen_off(gen_off),
  .eff_mode(eff_mode), .chg_pending(chg_pending), .prescale(prescale)
);

// File: tb/tb_clkmode_ctl_reg.sv
module tb_clkmode_ctl_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ref_ready = 1'b0;
  logic       chg_done = 1'b0;
  logic       gen_off = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] eff_mode;
  logic       chg_pending;
  logic [6:0] prescale;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  bit m_range, m_ref, m_stop, m_wseen, m_first, m_lock, m_pend;
  int m_mode, m_eff;

  clkmode_ctl_reg dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ref_ready(ref_ready), .chg_done(chg_done), .gen_off(gen_off),
    .eff_mode(eff_mode), .chg_pending(chg_pending), .prescale(prescale)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_range = 1; m_ref = 0; m_stop = 1; m_wseen = 0;
      m_first = 0; m_lock = 0; m_pend = 0; m_mode = 0; m_eff = 0;
    end else begin
      bit old_pend;
      old_pend = m_pend;
      if (old_pend && chg_done && !gen_off && (m_mode != 2 || ref_ready)) begin
        m_eff = m_mode; m_pend = 0;
      end
      if (wr_en) begin
        int v;
        bit ok;
        if (!m_wseen) begin m_range = wr_data[2]; m_ref = wr_data[1]; end
        m_wseen = 1;
        m_stop = wr_data[0];
        if (!old_pend) begin
          v = int'(wr_data[5:4]);
          ok = 1;
          if (!m_first) begin m_first = 1; m_lock = (v < 2); end
          else if (m_lock && v >= 2) ok = 0;
          if (ok && v != m_mode) begin m_mode = v; m_pend = 1; end
        end
      end
    end
  end

  function automatic int exp_rd();
    return (m_mode << 4) | (int'(m_range) << 2) | (int'(m_ref) << 1) | int'(m_stop);
  endfunction

  function automatic int exp_pre();
    return (m_eff >= 2 && !m_range) ? 64 : 1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      check("R2/R3/R4/R5/R7", "model rd_data", int'(rd_data), exp_rd());
      check("R6/R8/R9/R11", "model eff_mode", int'(eff_mode), m_eff);
      check("R8", "model chg_pending", int'(chg_pending), int'(m_pend));
      check("R10", "model prescale", int'(prescale), exp_pre());
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1; wr_en = 0; chg_done = 0; gen_off = 0; ref_ready = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); chg_done = 1;
    @(negedge clk); chg_done = 0;
  endtask

  task automatic wr_and_pulse(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d; chg_done = 1;
    @(negedge clk); wr_en = 0; chg_done = 0;
  endtask

  initial begin
    do_reset();
    cmp_en = 1;
    @(negedge clk);
    check("R1", "reset rd_data", int'(rd_data), 8'h05);
    check("R1", "reset eff_mode", int'(eff_mode), 0);
    check("R1", "reset pending", int'(chg_pending), 0);
    check("R1", "reset prescale", int'(prescale), 1);

    // first write: mode 01 (locks out 1x), range 0, ref 1, stop 0
    wr(8'h12);
    check("R8", "pending after change", int'(chg_pending), 1);
    check("R8", "eff held while pending", int'(eff_mode), 0);
    check("R2", "rd after first write", int'(rd_data), 8'h12);
    pulse();
    check("R8", "eff after done", int'(eff_mode), 1);
    check("R10", "internal mode ignores range 0", int'(prescale), 1);
    wr(8'h25);
    check("R5", "locked mode 10 write, rd", int'(rd_data), 8'h13);
    check("R3", "ref select frozen", int'(rd_data[1]), 1);
    check("R2", "range frozen", int'(rd_data[2]), 0);
    wr(8'hFF);
    check("R4", "reserved bits and lockout", int'(rd_data), 8'h13);
    check("R5", "no pending on blocked write", int'(chg_pending), 0);
    wr(8'h03);
    check("R5", "mode 00 allowed under lockout", int'(rd_data), 8'h03);
    check("R4", "stop bit written", int'(rd_data[0]), 1);
    pulse();

    do_reset();
    wr(8'h21);
    check("R5", "first write mode 10", int'(rd_data), 8'h21);
    pulse();
    check("R6", "bypass waits for ref_ready", int'(eff_mode), 0);
    check("R6", "still pending", int'(chg_pending), 1);
    wr(8'h30);
    check("R7", "write while pending keeps mode", int'(rd_data[5:4]), 2);
    check("R4", "stop still written while pending", int'(rd_data[0]), 0);
    ref_ready = 1; gen_off = 1;
    pulse();
    check("R9", "off mode blocks completion", int'(chg_pending), 1);
    check("R9", "off mode keeps stored mode", int'(rd_data[5:4]), 2);
    gen_off = 0;
    pulse();
    check("R6", "bypass taken with ref_ready", int'(eff_mode), 2);
    check("R10", "external range 0 gives 64", int'(prescale), 64);
    wr(8'h31);
    wr_and_pulse(8'h01);
    check("R11", "same cycle: completion taken", int'(eff_mode), 3);
    check("R11", "same cycle: write dropped", int'(rd_data[5:4]), 3);
    check("R11", "same cycle: pending cleared", int'(chg_pending), 0);
    wr(8'h01);
    check("R5", "no lockout after 1x first write", int'(rd_data[5:4]), 0);
    pulse();
    check("R10", "self-clocked prescale", int'(prescale), 1);
    wr(8'h01);
    check("R8", "same value write opens no change", int'(chg_pending), 0);

    do_reset();
    wr(8'h34);
    pulse();
    check("R10", "external range 1 gives 1", int'(prescale), 1);
    check("R8", "eff mode 11", int'(eff_mode), 3);

    // random phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rst       = ($urandom % 200) == 0;
      wr_en     = ($urandom % 3) == 0;
      wr_data   = 8'($urandom);
      chg_done  = ($urandom % 3) == 0;
      ref_ready = ($urandom % 4) != 0;
      gen_off   = ($urandom % 6) == 0;
    end
    @(negedge clk);
    rst = 0; wr_en = 0; chg_done = 0; gen_off = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule